// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between a processor and main memory and keeps recently used memory lines close to the processor. Every set holds two ways; each way carries one tag, one valid flag and a line of four 32-bit words. A read is looked up in both ways at once. On a hit the chosen word comes back in the same cycle. On a miss the whole 128-bit line is brought in from memory in a single transfer, written into the way picked for replacement, and the requested word is passed straight through to the processor in the cycle the transfer completes.

Writes always travel to memory. When the written address is already cached, the matching word in the line is updated as well. A write that misses leaves the cache untouched. The processor drives a request and keeps its address and data steady until the block raises ready. Byte extraction inside the returned word is left to the processor.

Top module: `cache_2way_wt`

## Requirements
- R1: The byte address is split as follows: the tag is bits 31 down to 4+INDEX_W, the set index is bits 3+INDEX_W down to 4, the word select is bits 3:2 and bits 1:0 are the byte select. With INDEX_W=13, address 0x0F3F4024 gives tag 0x079F, set 0x1402 and word 1.
- R2: After reset every line is invalid, cpu_ready and mem_req are 0, and the first read of any address misses.
- R3: A read that hits raises cpu_ready and cpu_hit in the same cycle as the request, returns the stored word on cpu_rdata and makes no memory request.
- R4: A way matches only when its valid flag is set and its stored tag equals the address tag; at most one way of a set matches.
- R5: A read miss raises mem_req with mem_we=0 in the cycle after the request, with mem_addr equal to the address with bits 3:0 cleared, and holds it until mem_ack. In the mem_ack cycle cpu_ready is 1, cpu_hit is 0 and cpu_rdata is mem_rdata bits 32*w+31 down to 32*w, where w is the word select.
- R6: A fill stores the whole line, its tag and a set valid flag into one way, so later reads of any word of that line hit.
- R7: The way filled is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the less recently used way. Read hits, fills and write hits each mark the used way as most recently used.
- R8: Every write raises mem_req with mem_we=1 in the cycle after the request, with mem_addr equal to cpu_addr and mem_wdata equal to cpu_wdata; it completes with cpu_ready=1 and cpu_hit=0 in the mem_ack cycle.
- R9: A write that hits updates only the addressed word of the matching line; the other three words keep their values.
- R10: A write that misses allocates nothing: a later read of that address still misses and returns the memory contents.
- R11: The byte select bits have no effect on lookup or on the returned word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when cpu_ready on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | 1 when a read hits in the cache |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory address (line base for fills) |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 128 | Line returned by memory, word 0 in the low bits |
| mem_ack | input | 1 | Memory completes the request this cycle |

## Verification
The bench builds the cache with INDEX_W=3, giving eight sets and a 25-bit tag, while the default is INDEX_W=5. With so few sets a handful of addresses that share a set index but differ in tag fill both ways and force replacement, so the invalid-way preference, the recency order and eviction followed by a refetch are all reached within a few hundred accesses. A random phase confined to two sets and four tags with varied memory latency keeps conflicts, write hits and write misses frequent.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int LINE_W  = WORD_W * WORDS;
  localparam int OFF_W   = 4;

  typedef enum logic {ST_IDLE, ST_MEM} ctrl_st_e;

  function automatic logic [1:0] word_of(input logic [31:0] a);
    return a[3:2];
  endfunction

  function automatic logic [31:0] set_of(input logic [31:0] a, input int iw);
    return (a >> OFF_W) & ((32'd1 << iw) - 32'd1);
  endfunction

  function automatic logic [31:0] tag_of(input logic [31:0] a, input int iw);
    return a >> (OFF_W + iw);
  endfunction

  function automatic logic [31:0] line_base(input logic [31:0] a);
    return {a[31:4], 4'b0000};
  endfunction

  function automatic logic [31:0] pick_word(input logic [LINE_W-1:0] line, input logic [1:0] w);
    return line[{w, 5'b00000} +: WORD_W];
  endfunction
endpackage

// File: rtl/cache_way.sv
module cache_way #(
  parameter int INDEX_W = 5,
  parameter int TAG_W   = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [INDEX_W-1:0]          idx,
  input  logic [TAG_W-1:0]            tag,
  input  logic [1:0]                  wsel,
  output logic                        match,
  output logic                        vld,
  output logic [31:0]                 word,
  input  logic                        fill_en,
  input  logic [cache_pkg::LINE_W-1:0] fill_line,
  input  logic [3:0]                  lane_en,
  input  logic [cache_pkg::LINE_W-1:0] lane_data
);
  import cache_pkg::*;
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= tag;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[idx] <= fill_line;
    end else begin
      for (int l = 0; l < WORDS; l++)
        if (lane_en[l]) data_q[idx][l*WORD_W +: WORD_W] <= lane_data[l*WORD_W +: WORD_W];
    end
  end

  assign vld   = valid_q[idx];
  assign match = valid_q[idx] && (tag_q[idx] == tag);
  assign word  = pick_word(data_q[idx], wsel);
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int INDEX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  input  logic [1:0]         way_vld,
  input  logic               upd_en,
  input  logic               used_way,
  output logic               victim
);
  localparam int SETS = 1 << INDEX_W;
  logic [SETS-1:0] repl_q;   // way to replace when both valid

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      repl_q <= '0;
    else if (upd_en) repl_q[idx] <= ~used_way;
  end

  always_comb begin
    if (!way_vld[0])      victim = 1'b0;
    else if (!way_vld[1]) victim = 1'b1;
    else                  victim = repl_q[idx];
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic hit_any,
  input  logic mem_ack,
  output logic mem_req,
  output logic cpu_ready,
  output logic rd_hit,
  output logic fill_go,
  output logic wr_go,
  output logic done
);
  import cache_pkg::*;
  ctrl_st_e st_q, st_d;

  assign rd_hit    = (st_q == ST_IDLE) && cpu_req && !cpu_we && hit_any;
  assign mem_req   = (st_q == ST_MEM);
  assign done      = mem_req && mem_ack;
  assign cpu_ready = rd_hit || done;
  assign fill_go   = done && !cpu_we;
  assign wr_go     = done && cpu_we && hit_any;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (cpu_req && !rd_hit) st_d = ST_MEM;
      ST_MEM:  if (mem_ack)            st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/cache_2way_wt.sv
module cache_2way_wt #(
  parameter int INDEX_W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_req,
  input  logic         cpu_we,
  input  logic [31:0]  cpu_addr,
  input  logic [31:0]  cpu_wdata,
  output logic [31:0]  cpu_rdata,
  output logic         cpu_ready,
  output logic         cpu_hit,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic [127:0] mem_rdata,
  input  logic         mem_ack
);
  import cache_pkg::*;
  localparam int TAG_W = 32 - OFF_W - INDEX_W;
  localparam int WAYS  = 2;

  logic [INDEX_W-1:0]        a_idx;
  logic [TAG_W-1:0]          a_tag;
  logic [1:0]                a_word;
  logic                      unused_byte_sel;
  logic [WAYS-1:0]           way_match, way_vld, way_fill;
  logic [WAYS-1:0][31:0]     way_word;
  logic [WAYS-1:0][3:0]      lane_en;
  logic [LINE_W-1:0]         lane_data;
  logic                      hit_any, hit_way, victim;
  logic                      rd_hit, fill_go, wr_go, done;
  logic                      lru_upd, lru_way;

  assign a_idx           = INDEX_W'(set_of(cpu_addr, INDEX_W));
  assign a_tag           = TAG_W'(tag_of(cpu_addr, INDEX_W));
  assign a_word          = word_of(cpu_addr);
  assign unused_byte_sel = ^cpu_addr[1:0];

  assign hit_any   = |way_match;
  assign hit_way   = way_match[1];
  assign lane_data = {WORDS{cpu_wdata}};

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_fill[w] = fill_go && (victim == 1'(w));
      assign lane_en[w]  = (wr_go && way_match[w]) ? (4'b0001 << a_word) : 4'b0000;
      cache_way #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_way (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (a_idx),
        .tag       (a_tag),
        .wsel      (a_word),
        .match     (way_match[w]),
        .vld       (way_vld[w]),
        .word      (way_word[w]),
        .fill_en   (way_fill[w]),
        .fill_line (mem_rdata),
        .lane_en   (lane_en[w]),
        .lane_data (lane_data)
      );
    end
  endgenerate

  assign lru_upd = rd_hit || wr_go || fill_go;
  assign lru_way = fill_go ? victim : hit_way;

  cache_lru #(.INDEX_W(INDEX_W)) i_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (a_idx),
    .way_vld  (way_vld),
    .upd_en   (lru_upd),
    .used_way (lru_way),
    .victim   (victim)
  );

  cache_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .hit_any   (hit_any),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .cpu_ready (cpu_ready),
    .rd_hit    (rd_hit),
    .fill_go   (fill_go),
    .wr_go     (wr_go),
    .done      (done)
  );

  assign cpu_hit   = rd_hit;
  assign cpu_rdata = fill_go ? pick_word(mem_rdata, a_word) : way_word[hit_way];
  assign mem_we    = mem_req && cpu_we;
  assign mem_addr  = cpu_we ? cpu_addr : line_base(cpu_addr);
  assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/cache_2way_wt_sva.sv
module cache_2way_wt_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_we,
  input logic        cpu_ready,
  input logic        cpu_hit,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [1:0]  match,
  input logic        fill_en,
  input logic        wr_en,
  input logic [7:0]  lanes
);
  a_r4_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r3_hit_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_ready && !mem_req && !cpu_we);

  a_r8_write_via_memory: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> mem_req && mem_ack);

  a_r6_fill_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> match == 2'b00);

  a_r9_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(lanes));

  a_r10_no_write_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && mem_req |-> !fill_en);
endmodule

bind cache_2way_wt cache_2way_wt_sva i_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_we    (cpu_we),
  .cpu_ready (cpu_ready),
  .cpu_hit   (cpu_hit),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .match     (way_match),
  .fill_en   (fill_go),
  .wr_en     (wr_go),
  .lanes     (lane_en)
);

// File: tb/test_cache_2way_wt.sv
module test_cache_2way_wt;
  localparam int IW   = 3;
  localparam int SETS = 1 << IW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready, cpu_hit;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  always #5 clk = ~clk;

  cache_2way_wt #(.INDEX_W(IW)) i_cache_2way_wt (.*);

  int checks = 0, errors = 0;

  // behavioural reference state
  bit          m_val [SETS][2];
  logic [31:0] m_tag [SETS][2];
  logic [31:0] m_dat [SETS][2][4];
  bit          m_old [SETS];          // way to evict when both valid
  logic [31:0] memw  [int unsigned];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int unsigned k = a >> 2;
    if (memw.exists(k)) return memw[k];
    return ((a & 32'hFFFF_FFFC) * 32'h9E37_79B1) ^ 32'h1357_0000;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input int dly, input string req);
    int s = int'((a >> 4) % SETS);
    logic [31:0] t = a >> (4 + IW);
    int w = int'(a[3:2]);
    int hw = -1;
    for (int k = 0; k < 2; k++) if (m_val[s][k] && m_tag[s][k] == t) hw = k;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #2;
    if (!we && hw >= 0) begin
      check({req, " R3"}, "ready", cpu_ready, 1);
      check({req, " R3"}, "hit", cpu_hit, 1);
      check({req, " R3"}, "rdata", cpu_rdata, m_dat[s][hw][w]);
      check({req, " R3"}, "mem_req", mem_req, 0);
      m_old[s] = (hw == 0);
      @(posedge clk);
    end else begin
      check({req, we ? " R8" : " R5"}, "ready early", cpu_ready, 0);
      check({req, we ? " R8" : " R5"}, "hit early", cpu_hit, 0);
      @(posedge clk);
      for (int k = 0; k <= dly; k++) begin
        @(negedge clk);
        if (k == dly) begin
          mem_ack = 1'b1;
          for (int i = 0; i < 4; i++)
            mem_rdata[32*i +: 32] = mem_word({a[31:4], 4'b0} + 32'(4*i));
        end
        #2;
        check({req, we ? " R8" : " R5"}, "mem_req", mem_req, 1);
        check({req, we ? " R8" : " R5"}, "mem_we", mem_we, we);
        check({req, we ? " R8" : " R5"}, "mem_addr", mem_addr, we ? a : {a[31:4], 4'b0});
        if (we) check({req, " R8"}, "mem_wdata", mem_wdata, wd);
        if (k < dly) check({req, " R5"}, "ready while waiting", cpu_ready, 0);
        else begin
          check({req, " R5"}, "ready at ack", cpu_ready, 1);
          check({req, " R5"}, "hit at ack", cpu_hit, 0);
          if (!we) check({req, " R5"}, "forwarded word", cpu_rdata, mem_word(a));
        end
        @(posedge clk);
      end
      if (we) begin
        memw[a >> 2] = wd;
        if (hw >= 0) begin m_dat[s][hw][w] = wd; m_old[s] = (hw == 0); end
      end else begin
        int v = !m_val[s][0] ? 0 : (!m_val[s][1] ? 1 : int'(m_old[s]));
        m_val[s][v] = 1'b1; m_tag[s][v] = t; m_old[s] = (v == 0);
        for (int i = 0; i < 4; i++) m_dat[s][v][i] = mem_word({a[31:4], 4'b0} + 32'(4*i));
      end
    end
    #1;
    cpu_req = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin m_val[s][0] = 0; m_val[s][1] = 0; m_old[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R2", "ready after reset", cpu_ready, 0);
    check("R2", "mem_req after reset", mem_req, 0);

    // R2: first read misses; fills way 0 (R7)
    access(0, 32'h0000_1234, 0, 2, "R2");
    // R6: other words of the filled line hit
    access(0, 32'h0000_1238, 0, 0, "R6");
    access(0, 32'h0000_1230, 0, 0, "R6");
    // R11: byte select ignored
    access(0, 32'h0000_1237, 0, 0, "R11");
    // R1: differs only in lowest tag bit (bit 7): same set, must miss, fills way 1
    access(0, 32'h0000_12B4, 0, 1, "R1");
    // R1: differs only in set bit: separate set, misses
    access(0, 32'h0000_1244, 0, 0, "R1");
    // R7: touch first line, then a third tag evicts the second line
    access(0, 32'h0000_1234, 0, 0, "R7");
    access(0, 32'h0000_1334, 0, 3, "R7");
    access(0, 32'h0000_1234, 0, 0, "R7");
    access(0, 32'h0000_12B4, 0, 0, "R7");
    // R9: write hit updates only one word
    access(1, 32'h0000_12B8, 32'hCAFE_0001, 1, "R9");
    access(0, 32'h0000_12B8, 0, 0, "R9");
    access(0, 32'h0000_12B4, 0, 0, "R9");
    access(0, 32'h0000_12BC, 0, 0, "R9");
    // R10: write miss does not allocate
    access(1, 32'h0000_5560, 32'h1234_ABCD, 0, "R10");
    access(0, 32'h0000_5560, 0, 2, "R10");
    // R4 / R7 random conflicts across two sets and four tags
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = (32'($urandom_range(0, 3)) << 7) | (32'($urandom_range(0, 1)) << 4)
                     | 32'($urandom_range(0, 15));
      access(bit'($urandom_range(0, 3) == 0), a, $urandom, $urandom_range(0, 3), "R4 R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule